// File: doc/BRIEF.md
# Link Symbol Scrambler with Periodic Reset

The block whitens the 8-bit symbols of one serial display link lane before line encoding. Each clock carries one symbol: a byte and a flag that marks it as a control symbol. Data bytes are XORed with eight bits of a 16-bit linear feedback shift register keystream. Control symbols leave unchanged, but the keystream still moves past them so that the receiver's descrambler stays in step.

A 2-bit mode input picks the behaviour. Scrambling can be off, on with a free-running keystream, or on with periodic resynchronisation. In the periodic mode the block counts blanking-start control symbols. On every 512th one it sends a scrambler-reset control symbol in that slot and reloads the register with its seed, so both ends realign. The output is registered, and a symbol appears one clock after it is presented.

Top module: `dp_scrambler`

## Requirements
- R1: While rst_ni is low, data_o and ctrl_o are 0. The register holds the seed 0xFFFF and the blanking-start count is 0.
- R2: In mode 2'b00, each symbol comes out unchanged on the next clock. The register stays at the seed and the count is cleared.
- R3: Mode 2'b10 behaves exactly as mode 2'b00.
- R4: In modes 2'b01 and 2'b11, a data symbol (ctrl_i=0) comes out as data_i XOR key. Key bit k, for k = 0 to 7, is state[15] before step k. One step makes state = {state[14:0], state[15]^state[4]^state[3]^state[2]}, and each symbol takes 8 steps.
- R5: A control symbol (ctrl_i=1) comes out with ctrl_o=1 and its byte unchanged. In modes 2'b01 and 2'b11 the register still takes 8 steps, except in the cases of R7 and R9.
- R6: In mode 2'b01, a blanking-start symbol (ctrl_i=1, byte 0xBC) is never replaced, however many arrive.
- R7: In mode 2'b11, the 512th blanking-start symbol since the count was last cleared comes out as the reset symbol (ctrl_o=1, byte 0x1C). The register reloads the seed, so the next data symbol uses the key of 0xFFFF, and the count restarts at 0.
- R8: In mode 2'b11, blanking-start symbols 1 to 511 of each period come out unchanged.
- R9: In mode 2'b11, an incoming reset symbol (ctrl_i=1, byte 0x1C) comes out unchanged and reloads the seed. It is not counted as a blanking-start symbol.
- R10: Any clock spent in mode 2'b00 or 2'b10 clears the blanking-start count. After a return to mode 2'b11, the first replacement falls on the 512th blanking-start symbol counted from that return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Symbol clock, one symbol per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 off, 01 scramble, 10 reserved (off), 11 scramble with periodic reset |
| data_i | input | 8 | Incoming symbol byte |
| ctrl_i | input | 1 | Marks the incoming symbol as a control symbol |
| data_o | output | 8 | Outgoing symbol byte |
| ctrl_o | output | 1 | Marks the outgoing symbol as a control symbol |

## Verification
The hardest point to reach is the boundary of a period. The replacement appears only after 511 earlier blanking-start symbols, and a single miscount moves it by one symbol. The stimulus mixes data bytes in among hundreds of blanking-start symbols, so the keystream position after the reload shows in the first data byte that follows. It also crosses the boundary twice and breaks a partial count with one clock in the off mode. In that last case a design that fails to clear the count substitutes too early.

// File: rtl/dp_scr_pkg.sv
package dp_scr_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam int unsigned SYM_W  = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  // taps below the top bit for x^16 + x^5 + x^4 + x^3 + 1
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h001C;
  localparam logic [SYM_W-1:0] BS_CODE = 8'hBC;
  localparam logic [SYM_W-1:0] SR_CODE = 8'h1C;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_FREE     = 2'b01,
    MODE_RSV      = 2'b10,
    MODE_PERIODIC = 2'b11
  } scr_mode_e;

  typedef struct packed {
    logic scr_en;
    logic per_en;
    logic is_bs;
    logic is_sr;
  } sym_class_t;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[LFSR_W-1] ^ (^(s & LFSR_TAPS));
    return {s[LFSR_W-2:0], fb};
  endfunction
endpackage

// File: rtl/dp_scr_lfsr.sv
module dp_scr_lfsr
  import dp_scr_pkg::*;
#(
  parameter int unsigned W = LFSR_W,
  parameter int unsigned STEPS = SYM_W,
  parameter logic [W-1:0] SEED = LFSR_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  output logic [STEPS-1:0] key_o,
  output logic [W-1:0]     state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = state_q;
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign key_o[g]    = chain[g][W-1];
    assign chain[g+1]  = lfsr_step(chain[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= chain[STEPS];
  end

  assign state_o = state_q;
endmodule

// File: rtl/dp_scr_bs_cnt.sv
module dp_scr_bs_cnt #(
  parameter int unsigned PERIOD = 512,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dp_scr_classify.sv
module dp_scr_classify
  import dp_scr_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic             ctrl_i,
  output sym_class_t       cls_o
);
  always_comb begin
    cls_o.scr_en = (mode_i == MODE_FREE) || (mode_i == MODE_PERIODIC);
    cls_o.per_en = (mode_i == MODE_PERIODIC);
    cls_o.is_bs  = ctrl_i && (data_i == BS_CODE);
    cls_o.is_sr  = ctrl_i && (data_i == SR_CODE);
  end
endmodule

// File: rtl/dp_scrambler.sv
module dp_scrambler
  import dp_scr_pkg::*;
#(
  parameter int unsigned BS_PERIOD = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic             ctrl_i,
  output logic [SYM_W-1:0] data_o,
  output logic             ctrl_o
);
  sym_class_t        cls;
  logic              bs_last;
  logic              subst;
  logic              reload;
  logic              advance;
  logic [SYM_W-1:0]  key;
  logic [LFSR_W-1:0] lfsr_state;
  logic [SYM_W-1:0]  data_d;

  dp_scr_classify u_cls (
    .mode_i (mode_i),
    .data_i (data_i),
    .ctrl_i (ctrl_i),
    .cls_o  (cls)
  );

  dp_scr_bs_cnt #(.PERIOD(BS_PERIOD)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!cls.per_en),
    .inc_i  (cls.per_en && cls.is_bs),
    .last_o (bs_last)
  );

  assign subst   = cls.per_en && cls.is_bs && bs_last;
  assign reload  = !cls.scr_en || subst || (cls.per_en && cls.is_sr);
  assign advance = cls.scr_en && !reload;

  dp_scr_lfsr #(.W(LFSR_W), .STEPS(SYM_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (advance),
    .load_i  (reload),
    .key_o   (key),
    .state_o (lfsr_state)
  );

  always_comb begin
    if (!cls.scr_en)  data_d = data_i;
    else if (subst)   data_d = SR_CODE;
    else if (ctrl_i)  data_d = data_i;
    else              data_d = data_i ^ key;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ctrl_o <= 1'b0;
    end else begin
      data_o <= data_d;
      ctrl_o <= ctrl_i;
    end
  end
endmodule

// File: rtl/dp_scrambler_chk.sv
module dp_scrambler_chk
  import dp_scr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [SYM_W-1:0]  data_i,
  input logic              ctrl_i,
  input logic [SYM_W-1:0]  data_o,
  input logic              ctrl_o,
  input logic [LFSR_W-1:0] lfsr_state
);
  // R2 R3
  off_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF || mode_i == MODE_RSV) |=>
      (data_o == $past(data_i)) && (ctrl_o == $past(ctrl_i)));

  // R5
  ctrl_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i |=> ctrl_o);

  // R5
  ctrl_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i && data_i != BS_CODE) |=> (data_o == $past(data_i)));

  // R6
  bs_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i && data_i == BS_CODE && mode_i != MODE_PERIODIC) |=> (data_o == BS_CODE));

  // R7
  seed_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == MODE_PERIODIC && ctrl_o && data_o == SR_CODE) |-> (lfsr_state == LFSR_SEED));
endmodule

bind dp_scrambler dp_scrambler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .data_i     (data_i),
  .ctrl_i     (ctrl_i),
  .data_o     (data_o),
  .ctrl_o     (ctrl_o),
  .lfsr_state (lfsr_state)
);

// File: tb/dp_scrambler_tb.sv
module dp_scrambler_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [7:0] data_i = 8'h00;
  logic       ctrl_i = 1'b0;
  logic [7:0] data_o;
  logic       ctrl_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0]  q_data[$];
  logic        q_ctrl[$];
  string       q_req[$];
  int          q_cyc[$];

  logic [15:0] m_s = 16'hFFFF;
  int          m_cnt = 0;

  dp_scrambler u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .data_i (data_i),
    .ctrl_i (ctrl_i),
    .data_o (data_o),
    .ctrl_o (ctrl_o)
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // model of the requirements; returns expected output
  task automatic send(input logic [1:0] m, input logic c, input logic [7:0] d, input string req);
    logic [7:0] ed;
    logic       en, per, bs, sr;
    logic [7:0] key;
    logic [15:0] s;
    en  = (m == 2'b01) || (m == 2'b11);
    per = (m == 2'b11);
    bs  = c && d == 8'hBC;
    sr  = c && d == 8'h1C;
    ed  = d;
    if (!en) begin
      m_s = 16'hFFFF;
    end else if (per && bs && m_cnt == 511) begin
      ed = 8'h1C; m_s = 16'hFFFF; m_cnt = 0;
    end else if (per && sr) begin
      m_s = 16'hFFFF;
    end else begin
      s = m_s;
      for (int k = 0; k < 8; k++) begin
        key[k] = s[15];
        s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
      end
      m_s = s;
      if (!c) ed = d ^ key;
      if (per && bs) m_cnt = m_cnt + 1;
    end
    if (!per) m_cnt = 0;
    @(negedge clk_i);
    mode_i = m; ctrl_i = c; data_i = d;
    q_data.push_back(ed); q_ctrl.push_back(c); q_req.push_back(req); q_cyc.push_back(cyc);
  endtask

  always @(negedge clk_i) begin
    #1;
    while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      logic [7:0] ed;
      logic       ec;
      string      r;
      int         c0;
      ed = q_data.pop_front(); ec = q_ctrl.pop_front(); r = q_req.pop_front(); c0 = q_cyc.pop_front();
      checks++;
      if (data_o !== ed || ctrl_o !== ec || cyc != c0 + 1) begin
        failures++;
        $display("FAIL %s: data_o=%h ctrl_o=%b expected %h %b (cycle %0d vs %0d)",
                 r, data_o, ctrl_o, ed, ec, cyc, c0 + 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    mode_i = 2'b11; ctrl_i = 1'b1; data_i = 8'hBC;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (data_o !== 8'h00 || ctrl_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: data_o=%h ctrl_o=%b expected 00 0", data_o, ctrl_o);
    end
    mode_i = 2'b00; ctrl_i = 1'b0; data_i = 8'h00;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 off mode
    for (int i = 0; i < 8; i++) send(2'b00, i[0], 8'(i * 37 + 5), "R2");
    send(2'b00, 1'b1, 8'hBC, "R2");
    // R3 reserved mode
    for (int i = 0; i < 8; i++) send(2'b10, i[1], 8'(i * 91 + 3), "R3");
    send(2'b10, 1'b0, 8'h00, "R3");
    // R4 free-running scrambling from seed
    send(2'b01, 1'b0, 8'h00, "R4");
    for (int i = 0; i < 20; i++) send(2'b01, 1'b0, 8'(i * 13), "R4");
    // R5 control symbols pass and keystream keeps moving
    send(2'b01, 1'b1, 8'h7C, "R5");
    send(2'b01, 1'b0, 8'hA5, "R5");
    send(2'b01, 1'b1, 8'hFB, "R5");
    send(2'b01, 1'b1, 8'h1C, "R5");
    send(2'b01, 1'b0, 8'h5A, "R5");
    // R6 many blanking-start symbols in free mode
    for (int i = 0; i < 600; i++) begin
      send(2'b01, 1'b1, 8'hBC, "R6");
      if (i % 50 == 0) send(2'b01, 1'b0, 8'h33, "R6");
    end
    // R7 R8 two full periods
    send(2'b00, 1'b0, 8'h00, "R2");
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 511; i++) begin
        send(2'b11, 1'b1, 8'hBC, "R8");
        if (i % 64 == 0) send(2'b11, 1'b0, 8'(i), "R8");
      end
      send(2'b11, 1'b1, 8'hBC, "R7");
      send(2'b11, 1'b0, 8'h00, "R7");
      send(2'b11, 1'b0, 8'hC3, "R7");
    end
    // R9 incoming reset symbol reloads seed and is not counted
    for (int i = 0; i < 100; i++) send(2'b11, 1'b1, 8'hBC, "R8");
    send(2'b11, 1'b0, 8'h11, "R9");
    send(2'b11, 1'b1, 8'h1C, "R9");
    send(2'b11, 1'b0, 8'h00, "R9");
    for (int i = 0; i < 411; i++) send(2'b11, 1'b1, 8'hBC, "R9");
    send(2'b11, 1'b1, 8'hBC, "R7");
    // R10 a cycle in off mode clears the count
    for (int i = 0; i < 300; i++) send(2'b11, 1'b1, 8'hBC, "R10");
    send(2'b10, 1'b0, 8'h44, "R10");
    for (int i = 0; i < 511; i++) send(2'b11, 1'b1, 8'hBC, "R10");
    send(2'b11, 1'b1, 8'hBC, "R10");
    send(2'b11, 1'b0, 8'h99, "R10");

    send(2'b00, 1'b0, 8'h00, "R2");
    repeat (3) @(negedge clk_i);
    done = 1;
    summary();
    $finish;
  end
endmodule